// File: doc/BRIEF.md
# Segmented Logarithm Approximation Unit

This unit computes an approximation of the natural logarithm of a positive signed fixed-point operand. It chooses one of sixteen coefficient segments whose input ranges grow by powers of ten. The choice is made by a binary search over decade thresholds, and it always takes exactly four comparisons. The unit then evaluates a five-term polynomial using the chosen segment's coefficients. A single multiplier is time-shared between the coefficient products and the running power of the operand.

Both lookup tables are loaded by software through one write port. The threshold table is indexed by the magnitude of the decade exponent. The coefficient table is indexed by segment and term. A request is taken through a valid/ready pair. The answer appears with a one-cycle valid strobe, together with a flag that reports whether any intermediate value was clamped. All intermediate values saturate at the limits of the fixed-point range.

Top module: `log_seg_unit`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and `out_result` and `out_sat` are 0.
- R2: An operand is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the result is ready. `out_valid` is high for exactly one cycle, 13 clock edges after the accepting edge. `in_ready` returns high in that same cycle, so a new request and a table write can land in the cycle the previous result is shown.
- R3: The search begins at decade exponent -16 with a step of 8. At each step the operand is compared as a signed value against the threshold held at table index equal to the negated exponent. If the operand equals the threshold, it counts as not below.
- R4: If the operand is below the threshold, the exponent decreases by the step. Otherwise the exponent increases by the step and the step is added to the segment index. The step halves after each of the four comparisons (8, 4, 2, 1), which gives a segment index from 0 to 15.
- R5: A write with `wr_sel`=0 stores `wr_data` as coefficient number `segment*5 + term`. A write with `wr_sel`=1 stores a threshold at index `wr_addr`, which is 1 to 31. Addresses beyond a table's size are dropped.
- R6: The result is the sum over i = 0 to 4 of c[i]·x^i. Each product is the full signed product shifted right arithmetically by FRAC bits and clamped to W bits. The power starts at 1.0 and is multiplied by x after each of the first four terms.
- R7: Sums are clamped to the signed W-bit range. `out_sat` is 1 when any product, power update or sum of that computation was clamped. It is cleared when a new operand is accepted.
- R8: Table writes made while a computation is in progress have no effect.
- R9: `out_result` and `out_sat` keep their values until the next result is delivered.
- R10: An operand below every visited threshold maps to segment 0. An operand at or above every visited threshold maps to segment 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand can be taken |
| in_data | input | W | Operand, signed fixed point with FRAC fraction bits |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | W | Approximated logarithm, same format |
| out_sat | output | 1 | Some intermediate of this result was clamped |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 = coefficient table, 1 = threshold table |
| wr_addr | input | ADDR_W | Table index |
| wr_data | input | W | Value to store |

## Verification
Two events can fall in the same cycle: the delivery of one result, and both a new acceptance and a table write. The bench provokes this by holding a request and a threshold write ready for the cycle the strobe appears. It checks that the old result is reported unchanged and that the write shapes the search of the new operand. Writes are also issued in the middle of a computation, and a rerun with the same operand shows that they changed nothing. A behavioural model that counts cycles judges the handshake, the strobe, the held result and the clamp flag on every clock.

// File: rtl/log_seg_pkg.sv
package log_seg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_TERM   = 2'd2,
        ST_POWER  = 2'd3
    } phase_e;
endpackage

// File: rtl/log_seg_mul.sv
module log_seg_mul #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] prod,
    output logic         ovf
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] full;
    logic signed [PW-1:0] scaled;

    always_comb begin
        full   = $signed(op_a) * $signed(op_b);
        scaled = full >>> FRAC;
        ovf    = (scaled[PW-1:W-1] != {(W+1){scaled[PW-1]}});
        if (ovf) begin
            prod = scaled[PW-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            prod = scaled[W-1:0];
        end
    end
endmodule

// File: rtl/log_seg_tables.sv
module log_seg_tables #(
    parameter int W   = 32,
    parameter int NC  = 80,
    parameter int TD  = 32,
    parameter int AW  = 7,
    parameter int CAW = 7,
    parameter int TAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           wr_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic           lock,
    input  logic [CAW-1:0] coef_addr,
    output logic [W-1:0]   coef_data,
    input  logic [TAW-1:0] thr_addr,
    output logic [W-1:0]   thr_data
);
    logic [W-1:0] coef_q [NC];
    logic [W-1:0] thr_q  [TD];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NC; i++) coef_q[i] <= '0;
            for (int i = 0; i < TD; i++) thr_q[i] <= '0;
        end else if (wr_en && !lock) begin
            if (!wr_sel && int'(wr_addr) < NC) coef_q[CAW'(wr_addr)] <= wr_data;
            if (wr_sel && int'(wr_addr) < TD) thr_q[TAW'(wr_addr)] <= wr_data;
        end
    end

    assign coef_data = coef_q[coef_addr];
    assign thr_data  = thr_q[thr_addr];

    // R8: a coefficient write while locked leaves the addressed entry as it was
    p_locked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lock && !wr_sel && int'(wr_addr) < NC)
        |=> coef_q[CAW'($past(wr_addr))] == $past(coef_q[CAW'(wr_addr)]));
endmodule

// File: rtl/log_seg_unit.sv
module log_seg_unit
    import log_seg_pkg::*;
#(
    parameter int W      = 32,
    parameter int FRAC   = 16,
    parameter int STEPS  = 4,
    parameter int NTERMS = 5,
    parameter int ADDR_W = $clog2((1 << STEPS) * NTERMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [W-1:0]      in_data,
    output logic              out_valid,
    output logic [W-1:0]      out_result,
    output logic              out_sat,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data
);
    localparam int NSEG = 1 << STEPS;
    localparam int NC   = NSEG * NTERMS;
    localparam int TD   = 2 << STEPS;
    localparam int CAW  = $clog2(NC);
    localparam int TAW  = $clog2(TD);
    localparam int EW   = STEPS + 2;
    localparam int SW   = STEPS;
    localparam int TW   = $clog2(NTERMS);
    localparam logic [W-1:0] ONE = W'(1) << FRAC;

    typedef struct packed {
        phase_e        st;
        logic [W-1:0]  x;
        logic [EW-1:0] expo;
        logic [SW-1:0] seg;
        logic [SW-1:0] step;
        logic [TW-1:0] term;
        logic [W-1:0]  pow;
        logic [W-1:0]  acc;
        logic          sat;
        logic          vld;
        logic [W-1:0]  res;
        logic          res_sat;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CAW-1:0] coef_addr;
    logic [TAW-1:0] thr_addr;
    logic [W-1:0]   coef_data, thr_data;
    logic [W-1:0]   mul_a, mul_b, mul_p;
    logic           mul_ovf;
    logic [W:0]     sum_wide;
    logic           add_ovf;
    logic [W-1:0]   sum_sat;
    logic           below;

    assign in_ready   = (ctx_q.st == ST_IDLE);
    assign out_valid  = ctx_q.vld;
    assign out_result = ctx_q.res;
    assign out_sat    = ctx_q.res_sat;
    assign coef_addr  = CAW'(ctx_q.seg) * CAW'(NTERMS) + CAW'(ctx_q.term);
    assign thr_addr   = TAW'(-ctx_q.expo);

    log_seg_tables #(
        .W(W), .NC(NC), .TD(TD), .AW(ADDR_W), .CAW(CAW), .TAW(TAW)
    ) u_tables (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .lock      (!in_ready),
        .coef_addr (coef_addr),
        .coef_data (coef_data),
        .thr_addr  (thr_addr),
        .thr_data  (thr_data)
    );

    log_seg_mul #(.W(W), .FRAC(FRAC)) u_mul (
        .op_a (mul_a),
        .op_b (mul_b),
        .prod (mul_p),
        .ovf  (mul_ovf)
    );

    always_comb begin
        mul_a    = (ctx_q.st == ST_POWER) ? ctx_q.pow : coef_data;
        mul_b    = (ctx_q.st == ST_POWER) ? ctx_q.x   : ctx_q.pow;
        sum_wide = {ctx_q.acc[W-1], ctx_q.acc} + {mul_p[W-1], mul_p};
        add_ovf  = (sum_wide[W] != sum_wide[W-1]);
        if (add_ovf) begin
            sum_sat = sum_wide[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            sum_sat = sum_wide[W-1:0];
        end
        below = ($signed(ctx_q.x) < $signed(thr_data));
    end

    always_comb begin
        ctx_d     = ctx_q;
        ctx_d.vld = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    ctx_d.st   = ST_SEARCH;
                    ctx_d.x    = in_data;
                    ctx_d.expo = EW'(-(1 << STEPS));
                    ctx_d.seg  = '0;
                    ctx_d.step = SW'(1 << (STEPS - 1));
                    ctx_d.sat  = 1'b0;
                end
            end
            ST_SEARCH: begin
                if (below) begin
                    ctx_d.expo = ctx_q.expo - EW'(ctx_q.step);
                end else begin
                    ctx_d.expo = ctx_q.expo + EW'(ctx_q.step);
                    ctx_d.seg  = ctx_q.seg + ctx_q.step;
                end
                ctx_d.step = ctx_q.step >> 1;
                if (ctx_q.step == SW'(1)) begin
                    ctx_d.st   = ST_TERM;
                    ctx_d.term = '0;
                    ctx_d.pow  = ONE;
                    ctx_d.acc  = '0;
                end
            end
            ST_TERM: begin
                ctx_d.acc = sum_sat;
                ctx_d.sat = ctx_q.sat | mul_ovf | add_ovf;
                if (ctx_q.term == TW'(NTERMS - 1)) begin
                    ctx_d.st      = ST_IDLE;
                    ctx_d.vld     = 1'b1;
                    ctx_d.res     = sum_sat;
                    ctx_d.res_sat = ctx_q.sat | mul_ovf | add_ovf;
                end else begin
                    ctx_d.st = ST_POWER;
                end
            end
            ST_POWER: begin
                ctx_d.pow  = mul_p;
                ctx_d.sat  = ctx_q.sat | mul_ovf;
                ctx_d.term = ctx_q.term + TW'(1);
                ctx_d.st   = ST_TERM;
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    // R2: the result strobe lasts a single cycle
    p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2: an accepted operand makes the unit busy on the next cycle
    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R9: without a strobe the delivered result does not move
    p_hold_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_result) && $stable(out_sat)));

    // R4: every compared exponent is an even decade inside the table
    p_expo_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_SEARCH) |->
        ($signed(ctx_q.expo) <= -2 && $signed(ctx_q.expo) >= 2 - TD));

    // R7: once clamped, the flag stays set until the computation ends
    p_sat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.sat && ctx_q.st != ST_IDLE) |=> ctx_q.sat);
endmodule

// File: tb/log_seg_unit_tb.sv
module log_seg_unit_tb;
    localparam int W      = 32;
    localparam int FRAC   = 16;
    localparam int NTERMS = 5;
    localparam int NC     = 80;
    localparam int TD     = 32;
    localparam int AW     = 7;
    localparam int LAT    = 13;
    localparam int ONE    = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [W-1:0] in_data = '0;
    logic out_valid;
    logic [W-1:0] out_result;
    logic out_sat;
    logic wr_en = 1'b0;
    logic wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;

    int checks = 0;
    int fails  = 0;
    string cur_tag = "R6";

    always #10 clk = ~clk;

    log_seg_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_result(out_result), .out_sat(out_sat),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // behavioural reference state
    int coef_m [NC];
    int thr_m  [TD];
    int cnt = 0;
    bit exp_valid = 0;
    int last_res = 0;
    bit last_sat = 0;
    int x_m = 0;
    int r_tmp;
    bit s_tmp;

    function automatic int clamp(input longint v, output bit o);
        o = (v > 64'sd2147483647) || (v < -64'sd2147483648);
        if (!o) return int'(v);
        return (v < 0) ? 32'h8000_0000 : 32'h7fff_ffff;
    endfunction

    function automatic void ref_eval(input int x, output int res, output bit s);
        int e = -16;
        int st = 8;
        int sg = 0;
        int pw = ONE;
        int acc = 0;
        bit o;
        s = 0;
        for (int k = 0; k < 4; k++) begin
            if (x < thr_m[-e]) e = e - st;
            else begin e = e + st; sg = sg + st; end
            st = st / 2;
        end
        for (int i = 0; i < NTERMS; i++) begin
            int p;
            p = clamp((longint'(coef_m[sg*NTERMS+i]) * longint'(pw)) >>> FRAC, o);
            s |= o;
            acc = clamp(longint'(acc) + longint'(p), o);
            s |= o;
            if (i < NTERMS - 1) begin
                pw = clamp((longint'(pw) * longint'(x)) >>> FRAC, o);
                s |= o;
            end
        end
        res = acc;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt <= 0; exp_valid <= 0; last_res <= 0; last_sat <= 0;
        end else begin
            exp_valid <= (cnt == 1);
            if (cnt == 1) begin
                ref_eval(x_m, r_tmp, s_tmp);
                last_res <= r_tmp;
                last_sat <= s_tmp;
            end
            if (cnt == 0) begin
                if (wr_en && !wr_sel && int'(wr_addr) < NC) coef_m[int'(wr_addr)] = int'(wr_data);
                if (wr_en && wr_sel && int'(wr_addr) < TD) thr_m[int'(wr_addr)] = int'(wr_data);
                if (in_valid) begin cnt <= LAT; x_m <= int'(in_data); end
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // compared on every cycle against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(in_ready == (cnt == 0), "R2", "in_ready", in_ready, cnt == 0);
            check(out_valid == exp_valid, "R2", "out_valid", out_valid, exp_valid);
            check(int'(out_result) == last_res, exp_valid ? cur_tag : "R9",
                  "out_result", int'(out_result), last_res);
            check(out_sat == last_sat, exp_valid ? "R7" : "R9", "out_sat", out_sat, last_sat);
        end
    end

    task automatic finish_tb;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wr(input bit sel, input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // c0 = segment number (as fixed point) when use_seg, else c0_k
    task automatic set_coefs(input bit use_seg, input int c0_k, input int c1,
                             input int c2, input int c3, input int c4);
        for (int sg = 0; sg < 16; sg++) begin
            wr(0, sg*5 + 0, use_seg ? sg * ONE : c0_k);
            wr(0, sg*5 + 1, c1);
            wr(0, sg*5 + 2, c2);
            wr(0, sg*5 + 3, c3);
            wr(0, sg*5 + 4, c4);
        end
    endtask

    task automatic issue(input int x);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_idle;
        do @(negedge clk); while (cnt != 0);
        @(negedge clk);
    endtask

    task automatic run(input string tag, input int x);
        cur_tag = tag;
        issue(x);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        finish_tb();
    end

    initial begin
        for (int i = 0; i < NC; i++) coef_m[i] = 0;
        for (int i = 0; i < TD; i++) thr_m[i] = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        check(out_result == '0, "R1", "out_result", out_result, 0);
        check(out_sat == 1'b0, "R1", "out_sat", out_sat, 0);
        rst_n = 1'b1;

        // R5: threshold for exponent -m stored at index m, rising toward -1
        for (int m = 1; m < TD; m++) wr(1, m, (32 - m) * 4096);
        set_coefs(1, 0, 0, 0, 0, 0);

        // R3: equality with the first threshold goes up; one below goes down
        run("R3", 16 * 4096);
        run("R3", 16 * 4096 - 1);
        // R4: several search paths
        run("R4", 3 * 4096 + 5);
        run("R4", 25 * 4096);
        run("R4", 10 * 4096);
        run("R4", 29 * 4096 + 100);
        // R10: clamping to the end segments
        run("R10", 1);
        run("R10", 32'h7fff_0000);

        // R6: full polynomial
        set_coefs(1, 0, 32768, -16384, 4096, -2048);
        run("R6", 98304);
        run("R6", 40000);
        run("R6", 200000);

        // R8: writes while busy are dropped, then a rerun proves tables intact
        cur_tag = "R8";
        issue(98304);
        for (int i = 0; i < 5; i++) wr(0, 40 + i, 32'h0123_4567);
        wr(1, 16, 1);
        wait_idle();
        run("R8", 98304);

        // R2: new request and threshold write in the cycle the result appears
        cur_tag = "R2";
        issue(50000);
        do @(negedge clk); while (!exp_valid);
        in_valid = 1'b1; in_data = 150000;
        wr_en = 1'b1; wr_sel = 1'b1; wr_addr = AW'(16); wr_data = 40 * 4096;
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0;
        wait_idle();
        wr(1, 16, 16 * 4096);

        // R7: product clamp, sum clamp, then flag cleared by a clean run
        set_coefs(0, 0, 32'h7fff_0000, 0, 0, 0);
        run("R7", 131072);
        set_coefs(0, 32'h7fff_0000, ONE, 0, 0, 0);
        run("R7", ONE);
        set_coefs(1, 0, 0, 0, 0, 0);
        run("R7", 5000);

        repeat (3) @(negedge clk);
        finish_tb();
    end
endmodule